// File: doc/BRIEF.md
# SPI Serial Clock and Edge-Phase Generator

This block turns a fixed system clock into the serial clock of an SPI controller and tells a neighbouring shift engine when to move data out and when to capture data in. An 8-bit divider sets the serial clock period, and a 3-bit signalling field sets three things on their own: the idle level, the edge on which outgoing data changes and the edge on which incoming data is sampled. Because driving and sampling have separate phase controls, the two can share one edge, which is what allows operation at the full system clock rate.

A transfer starts when `en_i` is seen high. At that moment the block captures the divider, the signalling field, the lane width (1, 2 or 4 data lines) and a bit count. It then runs one serial clock cycle per group of bits moved in parallel and parks at the idle level. At divide-by-1 the serial clock is the system clock gated during the transfer, and every system cycle is one serial cycle.

The controller is written around five named states:
- `ST_IDLE` waits for the enable.
- `ST_SETUP` is the idle-level half of a period.
- `ST_ACTIVE` is the active-level half.
- `ST_FAST` handles the gated full-rate case.
- `ST_HOLD` is entered after the last group and holds there until the enable drops.

The transitions are:
- start: `ST_IDLE` to `ST_SETUP`, or to `ST_FAST` at divide-by-1.
- leading edge: `ST_SETUP` to `ST_ACTIVE`.
- trailing edge: `ST_ACTIVE` back to `ST_SETUP`, or to `ST_HOLD` after the last group.
- fast finish: `ST_FAST` to `ST_HOLD`.
- abort: any state to `ST_IDLE` when the enable is low.

Top module: `spi_sck_phase_gen`

## Requirements
- R1: With divider code D, the serial period is N system cycles, where N = D for D in 1..255 and N = 256 for D = 0. Each period first spends ceil(N/2) cycles at the idle level, then floor(N/2) cycles at the active level. The first period begins in the cycle after the enable is sampled high.
- R2: Signalling field bit 0 is the polarity: 0 means the clock idles low and 1 means it idles high. Bit 1 is the output phase and bit 2 is the input phase. When disabled, `sck_o` follows bit 0 of the live field.
- R3: With input phase 0, `sample_o` pulses for one cycle in the first system cycle after each leading (idle-to-active) edge. With input phase 1, it pulses after each trailing (active-to-idle) edge.
- R4: With output phase 1, `shift_o` pulses after every leading edge. With output phase 0, it pulses after every trailing edge except the final one, because the first group is presented before the clock starts.
- R5: Lane code 00 moves 1 bit per serial cycle, 01 moves 2, and 10 or 11 move 4. The number of serial cycles is the bit count divided by the width, rounded up. A bit count of 0 produces no clocks and no strobes.
- R6: `group_done_o` pulses together with each sample strobe, which is exactly once per group.
- R7: With D = 1, `sck_o` is the gated system clock. During each of the G transfer cycles it is at the active level while the system clock is low and at the idle level while it is high. Every one of those cycles carries a shift, a sample and a group-done pulse.
- R8: While the enable is low, no strobes are issued and the clock stays idle. Dropping the enable mid-transfer stops all strobes and edges from the next cycle on.
- R9: After the last group, the clock rests at the idle level and no further strobes appear while the enable stays high. A new transfer needs the enable to go low and then high.
- R10: The divider, signalling field, lane code and bit count are captured at the start of a transfer. Changes to them during the transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transfer enable; a rising level starts a transfer |
| div_i | input | 8 | Divider code; 0 means divide by 256 |
| sig_i | input | 3 | Signalling field: bit 0 polarity, bit 1 output phase, bit 2 input phase |
| lanes_i | input | 2 | Lane width code: 00 single, 01 dual, 1x quad |
| nbits_i | input | 8 | Number of bits in the transfer |
| sck_o | output | 1 | Serial clock |
| shift_o | output | 1 | Strobe: present the next output group |
| sample_o | output | 1 | Strobe: capture the input group |
| group_done_o | output | 1 | Pulse per completed group |

## Verification
The hardest situations to reach from the ports are the final trailing edge, where an output-phase-0 shift must be suppressed, and the gated full-rate clock, whose level changes between system clock edges. The bench sweeps small dividers, all eight signalling codes, every lane code and several bit counts. It compares every cycle against a period and half-period position computed from the requirement formulas. In divide-by-1 runs it samples `sck_o` in both halves of each system cycle. Separate runs drop the enable mid-period and rewrite every configuration input mid-transfer, then watch the ports for stray edges or changed timing.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_FAST   = 3'd3,
        ST_HOLD   = 3'd4
    } sck_state_e;

    localparam logic [1:0] LANE_X1 = 2'b00;
    localparam logic [1:0] LANE_X2 = 2'b01;

    localparam int SIG_CPOL_BIT = 0;
    localparam int SIG_OPH_BIT  = 1;
    localparam int SIG_IPH_BIT  = 2;

endpackage

// File: rtl/sck_div_decode.sv
module sck_div_decode #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_i,
    output logic             fast_o,
    output logic [DIV_W-1:0] lead_m1_o,
    output logic [DIV_W-1:0] act_m1_o
);
    localparam int FULL_W = DIV_W + 1;

    logic [FULL_W-1:0] period_n;
    logic [FULL_W-1:0] lead_len;
    logic [FULL_W-1:0] act_len;
    logic [FULL_W-1:0] lead_m1;
    logic [FULL_W-1:0] act_m1;

    always_comb begin
        if (div_i == '0) begin
            period_n = FULL_W'(1) << DIV_W;
        end else begin
            period_n = {1'b0, div_i};
        end
        lead_len  = (period_n + FULL_W'(1)) >> 1;
        act_len   = period_n >> 1;
        lead_m1   = lead_len - FULL_W'(1);
        act_m1    = (act_len == '0) ? '0 : (act_len - FULL_W'(1));
        lead_m1_o = lead_m1[DIV_W-1:0];
        act_m1_o  = act_m1[DIV_W-1:0];
        fast_o    = (div_i == DIV_W'(1));
    end
endmodule

// File: rtl/sck_group_calc.sv
module sck_group_calc #(
    parameter int NB_W = 8
) (
    input  logic [1:0]      lanes_i,
    input  logic [NB_W-1:0] nbits_i,
    output logic [NB_W-1:0] groups_o
);
    import spi_sck_pkg::*;

    localparam int EXT_W = NB_W + 2;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] sum2;
    logic [EXT_W-1:0] sum4;

    always_comb begin
        ext  = {2'b00, nbits_i};
        sum2 = ext + EXT_W'(1);
        sum4 = ext + EXT_W'(3);
        if (lanes_i == LANE_X1) begin
            groups_o = nbits_i;
        end else if (lanes_i == LANE_X2) begin
            groups_o = sum2[NB_W:1];
        end else begin
            groups_o = sum4[NB_W+1:2];
        end
    end
endmodule

// File: rtl/sck_edge_fsm.sv
module sck_edge_fsm #(
    parameter int DIV_W = 8,
    parameter int NB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [2:0]       sig_i,
    input  logic             fast_i,
    input  logic [DIV_W-1:0] lead_m1_i,
    input  logic [DIV_W-1:0] act_m1_i,
    input  logic [NB_W-1:0]  groups_i,
    output logic             idle_o,
    output logic             fast_o,
    output logic             act_o,
    output logic             cpol_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             done_o
);
    import spi_sck_pkg::*;

    sck_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lead_m1_q, lead_m1_d;
    logic [DIV_W-1:0] act_m1_q, act_m1_d;
    logic [NB_W-1:0]  grp_q, grp_d;
    logic             cpol_q, cpol_d;
    logic             oph_q, oph_d;
    logic             iph_q, iph_d;
    logic             act_q, act_d;
    logic             shift_q, shift_d;
    logic             sample_q, sample_d;

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        grp_d     = grp_q;
        lead_m1_d = lead_m1_q;
        act_m1_d  = act_m1_q;
        cpol_d    = cpol_q;
        oph_d     = oph_q;
        iph_d     = iph_q;
        act_d     = act_q;
        shift_d   = 1'b0;
        sample_d  = 1'b0;
        if (!en_i) begin
            state_d = ST_IDLE;
            act_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    act_d = 1'b0;
                    if (groups_i != '0) begin
                        grp_d     = groups_i;
                        lead_m1_d = lead_m1_i;
                        act_m1_d  = act_m1_i;
                        cpol_d    = sig_i[SIG_CPOL_BIT];
                        oph_d     = sig_i[SIG_OPH_BIT];
                        iph_d     = sig_i[SIG_IPH_BIT];
                        cnt_d     = lead_m1_i;
                        state_d   = fast_i ? ST_FAST : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == '0) begin
                        state_d  = ST_ACTIVE;
                        act_d    = 1'b1;
                        cnt_d    = act_m1_q;
                        sample_d = !iph_q;
                        shift_d  = oph_q;
                    end else begin
                        cnt_d = cnt_q - DIV_W'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (cnt_q == '0) begin
                        act_d    = 1'b0;
                        sample_d = iph_q;
                        if (grp_q == NB_W'(1)) begin
                            state_d = ST_HOLD;
                        end else begin
                            state_d = ST_SETUP;
                            cnt_d   = lead_m1_q;
                            grp_d   = grp_q - NB_W'(1);
                            shift_d = !oph_q;
                        end
                    end else begin
                        cnt_d = cnt_q - DIV_W'(1);
                    end
                end
                ST_FAST: begin
                    grp_d = grp_q - NB_W'(1);
                    if (grp_q == NB_W'(1)) begin
                        state_d = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            grp_q     <= '0;
            lead_m1_q <= '0;
            act_m1_q  <= '0;
            cpol_q    <= 1'b0;
            oph_q     <= 1'b0;
            iph_q     <= 1'b0;
            act_q     <= 1'b0;
            shift_q   <= 1'b0;
            sample_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            grp_q     <= grp_d;
            lead_m1_q <= lead_m1_d;
            act_m1_q  <= act_m1_d;
            cpol_q    <= cpol_d;
            oph_q     <= oph_d;
            iph_q     <= iph_d;
            act_q     <= act_d;
            shift_q   <= shift_d;
            sample_q  <= sample_d;
        end
    end

    // outputs
    always_comb begin
        idle_o   = (state_q == ST_IDLE);
        fast_o   = (state_q == ST_FAST);
        act_o    = act_q;
        cpol_o   = cpol_q;
        shift_o  = shift_q | fast_o;
        sample_o = sample_q | fast_o;
        done_o   = sample_q | fast_o;
    end

    // R8
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_IDLE && !shift_o && !sample_o));

    // R1
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP || state_q == ST_ACTIVE) |-> (cnt_q <= lead_m1_q));

    // R5
    grp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP || state_q == ST_ACTIVE || state_q == ST_FAST) |-> (grp_q != '0));

    // R3
    trail_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q && !act_q) |-> iph_q);

    // R3
    lead_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q && act_q) |-> !iph_q);

    // R4
    lead_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q && act_q) |-> oph_q);

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && en_i) |=> (state_q == ST_HOLD && !shift_o && !sample_o && !act_q));

endmodule

// File: rtl/spi_sck_phase_gen.sv
module spi_sck_phase_gen #(
    parameter int DIV_W = 8,
    parameter int NB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [2:0]       sig_i,
    input  logic [1:0]       lanes_i,
    input  logic [NB_W-1:0]  nbits_i,
    output logic             sck_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             group_done_o
);
    import spi_sck_pkg::*;

    logic             fast_cfg;
    logic [DIV_W-1:0] lead_m1;
    logic [DIV_W-1:0] act_m1;
    logic [NB_W-1:0]  groups;
    logic             in_idle;
    logic             in_fast;
    logic             act;
    logic             cpol;

    sck_div_decode #(.DIV_W(DIV_W)) div_dec_i (
        .div_i     (div_i),
        .fast_o    (fast_cfg),
        .lead_m1_o (lead_m1),
        .act_m1_o  (act_m1)
    );

    sck_group_calc #(.NB_W(NB_W)) grp_calc_i (
        .lanes_i  (lanes_i),
        .nbits_i  (nbits_i),
        .groups_o (groups)
    );

    sck_edge_fsm #(.DIV_W(DIV_W), .NB_W(NB_W)) edge_fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .sig_i     (sig_i),
        .fast_i    (fast_cfg),
        .lead_m1_i (lead_m1),
        .act_m1_i  (act_m1),
        .groups_i  (groups),
        .idle_o    (in_idle),
        .fast_o    (in_fast),
        .act_o     (act),
        .cpol_o    (cpol),
        .shift_o   (shift_o),
        .sample_o  (sample_o),
        .done_o    (group_done_o)
    );

    // serial clock: live idle level when idle, gated system clock at full rate
    always_comb begin
        if (in_idle) begin
            sck_o = sig_i[SIG_CPOL_BIT];
        end else begin
            sck_o = cpol ^ (act | (in_fast & ~clk));
        end
    end

    // R6
    done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group_done_o |-> sample_o);

endmodule

// File: tb/spi_sck_phase_gen_tb.sv
module spi_sck_phase_gen_tb_top;

    logic       clk;
    logic       rst_n;
    logic       en_i;
    logic [7:0] div_i;
    logic [2:0] sig_i;
    logic [1:0] lanes_i;
    logic [7:0] nbits_i;
    logic       sck_o;
    logic       shift_o;
    logic       sample_o;
    logic       group_done_o;

    int n_checks;
    int n_fail;

    spi_sck_phase_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .div_i        (div_i),
        .sig_i        (sig_i),
        .lanes_i      (lanes_i),
        .nbits_i      (nbits_i),
        .sck_o        (sck_o),
        .shift_o      (shift_o),
        .sample_o     (sample_o),
        .group_done_o (group_done_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int groups_of(input int nb, input int ln);
        int w;
        w = (ln == 0) ? 1 : ((ln == 1) ? 2 : 4);
        return (nb + w - 1) / w;
    endfunction

    // one transfer; compare every cycle against the formula model
    task automatic run_xfer(input int dv, input int sg, input int ln, input int nb, input bit perturb);
        int  per, h1, g, tot, span;
        bit  cpol, oph, iph, fast;
        int  bad_sck, bad_stb, a_sck, e_sck, a_stb, e_stb;
        bad_sck = 0; bad_stb = 0;
        a_sck = 0; e_sck = 0; a_stb = 0; e_stb = 0;
        per  = (dv == 0) ? 256 : dv;
        h1   = (per + 1) / 2;
        g    = groups_of(nb, ln);
        fast = (per == 1);
        cpol = sg[0]; oph = sg[1]; iph = sg[2];
        tot  = g * per;
        span = fast ? g + 3 : tot + 3;
        @(negedge clk);
        div_i = 8'(dv); sig_i = 3'(sg); lanes_i = 2'(ln); nbits_i = 8'(nb);
        en_i = 1'b1;
        for (int p = 0; p < span; p++) begin
            bit es, esh, esa, lead, trail, act;
            int got, want;
            @(negedge clk);
            #1;
            if (perturb && p == 2) begin
                div_i = 8'(dv + 3); sig_i = ~3'(sg); lanes_i = 2'(ln + 1); nbits_i = 8'(nb + 7);
            end
            if (fast) begin
                act = (p < g);
                esh = act; esa = act;
            end else begin
                act = 0; lead = 0; trail = 0;
                if (p < tot) begin
                    act   = ((p % per) >= h1);
                    lead  = ((p % per) == h1);
                    trail = ((p % per) == 0) && (p >= per);
                end else if (p == tot && g > 0) begin
                    trail = 1;
                end
                esa = iph ? trail : lead;
                esh = oph ? lead : (trail && (p != tot));
            end
            es = cpol ^ act;
            if (sck_o !== es && bad_sck == 0) begin
                bad_sck = 1; a_sck = int'(sck_o); e_sck = int'(es);
            end
            got  = {29'd0, shift_o, sample_o, group_done_o};
            want = {29'd0, esh, esa, esa};
            if (got != want && bad_stb == 0) begin
                bad_stb = 1; a_stb = got; e_stb = want;
            end
            if (fast) begin
                @(posedge clk);
                #1;
                if (sck_o !== cpol && bad_sck == 0) begin
                    bad_sck = 1; a_sck = int'(sck_o); e_sck = int'(cpol);
                end
            end
        end
        if (fast) begin
            check(bad_sck == 0, perturb ? "R7 R10 sck" : "R7 R2 sck", a_sck, e_sck);
            check(bad_stb == 0, perturb ? "R7 R10 strobes" : "R7 R5 R6 R9 strobes", a_stb, e_stb);
        end else begin
            check(bad_sck == 0, perturb ? "R10 R1 sck" : "R1 R2 sck", a_sck, e_sck);
            check(bad_stb == 0, perturb ? "R10 R3 R4 strobes" : "R3 R4 R5 R6 R9 strobes", a_stb, e_stb);
        end
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int divs[5];
        int nbl[3];
        n_checks = 0; n_fail = 0;
        divs = '{1, 2, 3, 4, 7};
        nbl  = '{1, 5, 8};
        rst_n = 1'b0; en_i = 1'b0; div_i = 8'd4; sig_i = 3'b001; lanes_i = 2'b00; nbits_i = 8'd8;
        repeat (3) @(negedge clk);
        #1;
        // R8 reset state: idle level from live field, no strobes
        check(sck_o === 1'b1, "R8 R2 reset sck", int'(sck_o), 1);
        check({shift_o, sample_o, group_done_o} === 3'b000, "R8 reset strobes",
              int'({shift_o, sample_o, group_done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        sig_i = 3'b000;
        #1;
        check(sck_o === 1'b0, "R2 idle low follows field", int'(sck_o), 0);

        for (int di = 0; di < 5; di++)
            for (int sg = 0; sg < 8; sg++)
                for (int ln = 0; ln < 3; ln++)
                    for (int ni = 0; ni < 3; ni++)
                        run_xfer(divs[di], sg, ln, nbl[ni], 1'b0);

        // R1 divide-by-256 code
        run_xfer(0, 3'b001, 2, 8, 1'b0);
        run_xfer(0, 3'b110, 0, 2, 1'b0);
        // R5 lane code 11 acts as quad; zero bit count gives nothing
        run_xfer(5, 3'b010, 3, 9, 1'b0);
        run_xfer(3, 3'b100, 0, 0, 1'b0);
        run_xfer(1, 3'b011, 0, 0, 1'b0);
        // R10 configuration rewritten mid-transfer
        run_xfer(6, 3'b101, 1, 7, 1'b1);
        run_xfer(1, 3'b100, 0, 6, 1'b1);

        // R8 abort mid-transfer
        begin
            int strays;
            int sck_bad;
            strays = 0; sck_bad = 0;
            @(negedge clk);
            div_i = 8'd4; sig_i = 3'b001; lanes_i = 2'b00; nbits_i = 8'd8;
            en_i = 1'b1;
            repeat (6) @(negedge clk);
            #1;
            en_i = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                #1;
                if (shift_o || sample_o || group_done_o) strays++;
                if (sck_o !== 1'b1) sck_bad++;
            end
            check(strays == 0, "R8 abort strobes", strays, 0);
            check(sck_bad == 0, "R8 abort sck idle", sck_bad, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule